// File: doc/BRIEF.md
# GPIO Edge/Level Interrupt Detector

This block watches 64 already-synchronized input pins and raises one interrupt line toward a parent interrupt controller. Each pin has its own detection mode. In level mode the pin's raw status follows the pin directly. In edge mode the pin latches on a rising edge, on a falling edge or on any transition, and the latched status stays set until software clears it. Software sets the block up, and reads it back, through a 32-bit register port with a single-cycle write strobe and a combinational read path.

Each per-pin vector is split over two 32-bit words. The word at the base offset holds pins 0–31, and the word 4 bytes above it holds pins 32–63. A global enable bit turns the interrupt output on and allows edges to be captured. A masked status view shows which pins currently request service.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After a synchronous reset the following are all zero: the global enable, the per-pin mode vectors, the interrupt-enable words and every latched edge. `irq_out` is low.
- R2: The register byte offsets are:
  - global enable (bit 0): 0x0DC
  - mode select: 0x0E0/0x0E4
  - clear: 0x0E8/0x0EC
  - any-edge: 0x0F0/0x0F4
  - polarity: 0x0F8/0x0FC
  - interrupt enable: 0x100/0x104
  - raw status: 0x108/0x10C
  - masked status: 0x110/0x114
  - pin data: 0x118/0x11C

  The lower offset of each pair covers pins 0–31 and the higher one covers pins 32–63. Every configuration register reads back what was last written to it. Unmapped offsets read as zero.
- R3: With a mode bit of 0 the pin is in level mode. Its raw status equals the pin when the polarity bit is 1, and the inverted pin when the polarity bit is 0. The raw status changes in the same cycle as the pin.
- R4: With a mode bit of 1 and an any-edge bit of 0, the pin is in edge mode. A polarity bit of 1 latches on a rising edge and a polarity bit of 0 latches on a falling edge. An edge is a difference between the current sample and the sample from the previous cycle. The latched bit is visible from the cycle after the edge and holds until cleared. Returning a pin to level mode discards its latched edge.
- R5: In edge mode with the any-edge bit set, both rising and falling transitions latch, whatever the polarity bit holds.
- R6: Writing a 1 to a bit of a clear word drops that pin's latched edge. Writing a 0 leaves it unchanged. The clear words read as zero.
- R7: A level-mode raw status bit cannot be cleared through the clear words.
- R8: When a new qualifying edge and a clear of the same pin fall in the same cycle, the edge wins and the bit stays set.
- R9: The masked status equals the raw status ANDed with the interrupt-enable bits, whatever the global enable holds.
- R10: `irq_out` is high exactly when the global enable is 1 and at least one masked status bit is set.
- R11: While the global enable is 0, no new edges latch, and level-mode raw status still follows the pins.
- R12: Writes to the raw status, masked status and pin data offsets have no effect. The pin data words return the current pin values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 9 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pins_in | input | 64 | Synchronized pin samples |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench goes after the following corner cases:
- **Clear and edge in the same cycle.** A design that let the clear win would lose an interrupt that occurred while software was acknowledging the previous one.
- **Clear words against level-mode pins.** A design that honoured the clear would show the pin as idle while it is still asserted.
- **Each edge mode against the wrong transition.** A design that ignored the polarity or any-edge bits would latch on a falling edge when set for rising, or the reverse.
- **Edges while the global enable is off.** A design that captured them would raise a stale interrupt as soon as the block is enabled.
- **Disable with the masked status still set.** A design that did not gate the output would keep `irq_out` high.
- **Return to level mode.** A design that kept the old latched edge would report it again once the pin went back to edge mode.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int PIN_COUNT = 64;
    localparam int WORD_W    = 32;
    localparam int N_WORDS   = PIN_COUNT / WORD_W;
    localparam int ADDR_W    = 9;

    typedef logic [PIN_COUNT-1:0] pin_vec_t;
    typedef logic [WORD_W-1:0]    word_t;
    typedef logic [ADDR_W-1:0]    addr_t;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_GEN, SEL_MODE, SEL_CLR, SEL_ANY,
        SEL_POL, SEL_IEN, SEL_RAW, SEL_MSK, SEL_PIN
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     hi;
    } reg_dec_t;

    typedef struct packed {
        pin_vec_t mode;
        pin_vec_t any;
        pin_vec_t pol;
        pin_vec_t ien;
        logic     en;
    } cfg_t;

    function automatic reg_dec_t decode(input addr_t a);
        reg_dec_t d;
        d.hi = a[2];
        case (a)
            9'h0DC:         d.sel = SEL_GEN;
            9'h0E0, 9'h0E4: d.sel = SEL_MODE;
            9'h0E8, 9'h0EC: d.sel = SEL_CLR;
            9'h0F0, 9'h0F4: d.sel = SEL_ANY;
            9'h0F8, 9'h0FC: d.sel = SEL_POL;
            9'h100, 9'h104: d.sel = SEL_IEN;
            9'h108, 9'h10C: d.sel = SEL_RAW;
            9'h110, 9'h114: d.sel = SEL_MSK;
            9'h118, 9'h11C: d.sel = SEL_PIN;
            default:        d.sel = SEL_NONE;
        endcase
        return d;
    endfunction

    function automatic word_t pick(input pin_vec_t v, input logic hi);
        return hi ? v[PIN_COUNT-1:WORD_W] : v[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  addr_t    addr,
    input  word_t    wdata,
    output cfg_t     cfg,
    output pin_vec_t clr_vec
);
    reg_dec_t dec;
    logic     en_q;
    pin_vec_t mode_v, any_v, pol_v, ien_v;

    assign dec = decode(addr);

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (wr_en && dec.sel == SEL_GEN)
            en_q <= wdata[0];
    end

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        logic  sel_w;
        word_t mode_w, any_w, pol_w, ien_w;

        assign sel_w = wr_en && (int'(dec.hi) == w);

        always_ff @(posedge clk) begin
            if (rst) begin
                mode_w <= '0;
                any_w  <= '0;
                pol_w  <= '0;
                ien_w  <= '0;
            end else if (sel_w) begin
                case (dec.sel)
                    SEL_MODE: mode_w <= wdata;
                    SEL_ANY:  any_w  <= wdata;
                    SEL_POL:  pol_w  <= wdata;
                    SEL_IEN:  ien_w  <= wdata;
                    default: ;
                endcase
            end
        end

        assign mode_v[w*WORD_W +: WORD_W]  = mode_w;
        assign any_v[w*WORD_W +: WORD_W]   = any_w;
        assign pol_v[w*WORD_W +: WORD_W]   = pol_w;
        assign ien_v[w*WORD_W +: WORD_W]   = ien_w;
        assign clr_vec[w*WORD_W +: WORD_W] = (sel_w && dec.sel == SEL_CLR) ? wdata : '0;
    end

    assign cfg.mode = mode_v;
    assign cfg.any  = any_v;
    assign cfg.pol  = pol_v;
    assign cfg.ien  = ien_v;
    assign cfg.en   = en_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t pins,
    input  cfg_t     cfg,
    input  pin_vec_t clr_vec,
    output pin_vec_t raw,
    output pin_vec_t hit,
    output pin_vec_t edge_q
);
    pin_vec_t prev_q;

    always_ff @(posedge clk) begin
        prev_q <= pins;
    end

    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
        logic rise, fall, lvl, qual, edge_b;

        always_comb begin
            rise = pins[p] & ~prev_q[p];
            fall = ~pins[p] & prev_q[p];
            lvl  = cfg.pol[p] ? pins[p] : ~pins[p];
            if (cfg.any[p])
                qual = rise | fall;
            else
                qual = cfg.pol[p] ? rise : fall;
        end

        assign hit[p] = qual & cfg.mode[p] & cfg.en;

        always_ff @(posedge clk) begin
            if (rst)
                edge_b <= 1'b0;
            else
                edge_b <= cfg.mode[p] & ((edge_b & ~clr_vec[p]) | hit[p]);
        end

        assign edge_q[p] = edge_b;
        assign raw[p]    = cfg.mode[p] ? edge_b : lvl;
    end

endmodule

// File: rtl/gpio_irq_readmux.sv
module gpio_irq_readmux
    import gpio_irq_pkg::*;
(
    input  addr_t    addr,
    input  cfg_t     cfg,
    input  pin_vec_t raw,
    input  pin_vec_t masked,
    input  pin_vec_t pins,
    output word_t    rdata
);
    reg_dec_t dec;

    always_comb begin
        dec = decode(addr);
        case (dec.sel)
            SEL_GEN:  rdata = {{(WORD_W-1){1'b0}}, cfg.en};
            SEL_MODE: rdata = pick(cfg.mode, dec.hi);
            SEL_ANY:  rdata = pick(cfg.any, dec.hi);
            SEL_POL:  rdata = pick(cfg.pol, dec.hi);
            SEL_IEN:  rdata = pick(cfg.ien, dec.hi);
            SEL_RAW:  rdata = pick(raw, dec.hi);
            SEL_MSK:  rdata = pick(masked, dec.hi);
            SEL_PIN:  rdata = pick(pins, dec.hi);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             bus_wr,
    input  logic [gpio_irq_pkg::ADDR_W-1:0]  bus_addr,
    input  logic [gpio_irq_pkg::WORD_W-1:0]  bus_wdata,
    output logic [gpio_irq_pkg::WORD_W-1:0]  bus_rdata,
    input  logic [gpio_irq_pkg::PIN_COUNT-1:0] pins_in,
    output logic                             irq_out
);
    cfg_t     cfg;
    pin_vec_t clr_vec, raw, hit, edge_q, masked;

    gpio_irq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .cfg     (cfg),
        .clr_vec (clr_vec)
    );

    gpio_irq_detect u_detect (
        .clk     (clk),
        .rst     (rst),
        .pins    (pins_in),
        .cfg     (cfg),
        .clr_vec (clr_vec),
        .raw     (raw),
        .hit     (hit),
        .edge_q  (edge_q)
    );

    assign masked  = raw & cfg.ien;
    assign irq_out = cfg.en & (|masked);

    gpio_irq_readmux u_rmux (
        .addr   (bus_addr),
        .cfg    (cfg),
        .raw    (raw),
        .masked (masked),
        .pins   (pins_in),
        .rdata  (bus_rdata)
    );

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     irq_out,
    input logic     en,
    input pin_vec_t edge_q,
    input pin_vec_t hit,
    input pin_vec_t clr_vec,
    input pin_vec_t mode
);
    pin_vec_t keep_v, drop_v;

    assign keep_v = edge_q & ~clr_vec & mode;
    assign drop_v = clr_vec & ~hit;

    AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq_out); // R1

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (|keep_v) |=> ((edge_q & $past(keep_v)) == $past(keep_v))); // R4

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (|drop_v) |=> ((edge_q & $past(drop_v)) == '0)); // R6

    AST_HIT_WINS: assert property (@(posedge clk) disable iff (rst)
        (|hit) |=> ((edge_q & $past(hit)) == $past(hit))); // R8

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !en |-> !irq_out); // R10

    AST_NO_LATCH_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> ((edge_q & ~$past(edge_q)) == '0)); // R11

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .irq_out (irq_out),
    .en      (cfg.en),
    .edge_q  (edge_q),
    .hit     (hit),
    .clr_vec (clr_vec),
    .mode    (cfg.mode)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] pins_in = '0;
    logic        irq_out;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    gpio_irq_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pins_in   (pins_in),
        .irq_out   (irq_out)
    );

    // behavioural reference model
    bit [63:0] m_mode, m_any, m_pol, m_ien, m_edge, m_prev, t_clr;
    bit        m_en;
    bit        t_r, t_f, t_h;

    function automatic bit [63:0] m_raw();
        bit [63:0] r = '0;
        for (int p = 0; p < 64; p++)
            r[p] = m_mode[p] ? m_edge[p] : (m_pol[p] ? pins_in[p] : !pins_in[p]);
        return r;
    endfunction

    function automatic bit m_irq();
        return m_en && ((m_raw() & m_ien) != 0);
    endfunction

    function automatic bit [31:0] m_read(input bit [8:0] a);
        bit [63:0] v = '0;
        case (a)
            9'h0DC: return {31'd0, m_en};
            9'h0E0, 9'h0E4: v = m_mode;
            9'h0F0, 9'h0F4: v = m_any;
            9'h0F8, 9'h0FC: v = m_pol;
            9'h100, 9'h104: v = m_ien;
            9'h108, 9'h10C: v = m_raw();
            9'h110, 9'h114: v = m_raw() & m_ien;
            9'h118, 9'h11C: v = pins_in;
            default: return 32'd0;
        endcase
        return a[2] ? v[63:32] : v[31:0];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = '0; m_any = '0; m_pol = '0; m_ien = '0; m_edge = '0; m_en = 1'b0;
            m_prev = pins_in;
        end else begin
            t_clr = '0;
            if (bus_wr && bus_addr == 9'h0E8) t_clr[31:0]  = bus_wdata;
            if (bus_wr && bus_addr == 9'h0EC) t_clr[63:32] = bus_wdata;
            for (int p = 0; p < 64; p++) begin
                t_r = pins_in[p] && !m_prev[p];
                t_f = !pins_in[p] && m_prev[p];
                t_h = m_any[p] ? (t_r || t_f) : (m_pol[p] ? t_r : t_f);
                t_h = t_h && m_en;
                if (!m_mode[p])    m_edge[p] = 1'b0;
                else if (t_h)      m_edge[p] = 1'b1;
                else if (t_clr[p]) m_edge[p] = 1'b0;
            end
            m_prev = pins_in;
            if (bus_wr) begin
                case (bus_addr)
                    9'h0DC: m_en = bus_wdata[0];
                    9'h0E0: m_mode[31:0]  = bus_wdata;
                    9'h0E4: m_mode[63:32] = bus_wdata;
                    9'h0F0: m_any[31:0]   = bus_wdata;
                    9'h0F4: m_any[63:32]  = bus_wdata;
                    9'h0F8: m_pol[31:0]   = bus_wdata;
                    9'h0FC: m_pol[63:32]  = bus_wdata;
                    9'h100: m_ien[31:0]   = bus_wdata;
                    9'h104: m_ien[63:32]  = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check(irq_out === m_irq(), "R10 irq vs model", {31'd0, irq_out}, {31'd0, m_irq()});
            check(bus_rdata === m_read(bus_addr), "R2 read vs model", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(input bit [8:0] a, input bit [31:0] d);
        @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic setpins(input bit [63:0] v);
        @(posedge clk); #2;
        pins_in = v;
    endtask

    task automatic rd(input bit [8:0] a, input bit [31:0] exp, input string tag);
        @(posedge clk); #2;
        bus_addr = a;
        @(negedge clk);
        check(bus_rdata === exp, tag, bus_rdata, exp);
    endtask

    task automatic chk_irq(input bit exp, input string tag);
        @(negedge clk);
        check(irq_out === exp, tag, {31'd0, irq_out}, {31'd0, exp});
    endtask

    initial begin
        #(8.0 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    localparam bit [63:0] P40 = 64'h1 << 40;

    initial begin
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;

        rd(9'h0DC, 32'h0, "R1 enable after reset");
        rd(9'h100, 32'h0, "R1 ien low after reset");
        rd(9'h104, 32'h0, "R1 ien high after reset");
        rd(9'h0E4, 32'h0, "R1 mode high after reset");
        chk_irq(1'b0, "R1 irq after reset");

        wr(9'h0DC, 32'h1);
        rd(9'h0DC, 32'h1, "R2 enable readback");

        // level mode, pin 3 active high
        wr(9'h0F8, 32'h8);
        wr(9'h100, 32'h8);
        setpins(64'h8);
        rd(9'h108, 32'hFFFF_FFFF, "R3 level raw high");
        rd(9'h110, 32'h0000_0008, "R9 masked low");
        chk_irq(1'b1, "R10 irq from level");
        setpins(64'h0);
        rd(9'h108, 32'hFFFF_FFF7, "R3 level raw follows low");
        chk_irq(1'b0, "R10 irq drops");
        setpins(64'h8);
        wr(9'h0E8, 32'h8);
        rd(9'h108, 32'hFFFF_FFFF, "R7 level not cleared");
        setpins(64'h0);

        // rising edge on pin 40
        wr(9'h0E4, 32'h100);
        wr(9'h0FC, 32'h100);
        rd(9'h10C, 32'hFFFF_FEFF, "R4 edge idle");
        setpins(P40);
        rd(9'h10C, 32'hFFFF_FFFF, "R4 rising latched");
        setpins(64'h0);
        rd(9'h10C, 32'hFFFF_FFFF, "R4 held after fall");
        wr(9'h0EC, 32'h0);
        rd(9'h10C, 32'hFFFF_FFFF, "R6 zero clear no effect");
        wr(9'h0EC, 32'h100);
        rd(9'h10C, 32'hFFFF_FEFF, "R6 one clears");
        rd(9'h0EC, 32'h0, "R6 clear reads zero");

        // falling edge
        wr(9'h0FC, 32'h0);
        setpins(P40);
        rd(9'h10C, 32'hFFFF_FEFF, "R4 rise ignored in falling mode");
        setpins(64'h0);
        rd(9'h10C, 32'hFFFF_FFFF, "R4 falling latched");
        wr(9'h0EC, 32'h100);

        // any edge, polarity ignored
        wr(9'h0F4, 32'h100);
        setpins(P40);
        rd(9'h10C, 32'hFFFF_FFFF, "R5 any-edge rise");
        wr(9'h0EC, 32'h100);
        rd(9'h10C, 32'hFFFF_FEFF, "R5 cleared");
        setpins(64'h0);
        rd(9'h10C, 32'hFFFF_FFFF, "R5 any-edge fall");
        wr(9'h0FC, 32'h100);
        wr(9'h0EC, 32'h100);
        setpins(P40);
        rd(9'h10C, 32'hFFFF_FFFF, "R5 polarity ignored");

        // edge and clear in the same cycle
        @(posedge clk); #2;
        pins_in = 64'h0; bus_wr = 1'b1; bus_addr = 9'h0EC; bus_wdata = 32'h100;
        @(posedge clk); #2;
        bus_wr = 1'b0;
        rd(9'h10C, 32'hFFFF_FFFF, "R8 edge beats clear");
        wr(9'h0EC, 32'h100);
        rd(9'h10C, 32'hFFFF_FEFF, "R8 clear alone");

        // masking and global enable
        setpins(P40);
        rd(9'h114, 32'h0, "R9 masked off");
        wr(9'h104, 32'h100);
        rd(9'h114, 32'h100, "R9 masked on");
        chk_irq(1'b1, "R10 irq from edge");
        wr(9'h0DC, 32'h0);
        chk_irq(1'b0, "R10 irq gated by enable");
        rd(9'h114, 32'h100, "R9 masked while disabled");

        // no capture while disabled
        wr(9'h0EC, 32'h100);
        setpins(64'h0);
        rd(9'h10C, 32'hFFFF_FEFF, "R11 fall not latched");
        setpins(P40 | 64'h8);
        rd(9'h10C, 32'hFFFF_FEFF, "R11 rise not latched");
        rd(9'h108, 32'hFFFF_FFFF, "R11 level still follows");

        // read-only words and pin data
        setpins(64'hA5A5_0000_0000_1234);
        rd(9'h118, 32'h0000_1234, "R12 pin data low");
        rd(9'h11C, 32'hA5A5_0000, "R12 pin data high");
        wr(9'h118, 32'hFFFF_FFFF);
        rd(9'h118, 32'h0000_1234, "R12 pin data write ignored");
        wr(9'h108, 32'h0);
        rd(9'h108, 32'hFFFF_EDC3, "R12 raw write ignored");
        rd(9'h0E4, 32'h100, "R2 mode readback");
        rd(9'h0F4, 32'h100, "R2 any readback");
        rd(9'h0F8, 32'h8, "R2 polarity readback");
        rd(9'h1F0, 32'h0, "R2 unmapped reads zero");

        // return to level mode discards latched edge
        wr(9'h0DC, 32'h1);
        setpins(64'hA5A5_0100_0000_1234);
        rd(9'h10C, 32'h5A5A_FFFF, "R5 latched before mode change");
        wr(9'h0E4, 32'h0);
        wr(9'h0E4, 32'h100);
        rd(9'h10C, 32'h5A5A_FEFF, "R4 level mode discards edge");

        // random traffic compared against the model every cycle
        for (int i = 0; i < 600; i++) begin
            bit [8:0] alist [12] = '{9'h0DC, 9'h0E0, 9'h0E4, 9'h0E8, 9'h0EC, 9'h0F0,
                                     9'h0F4, 9'h0F8, 9'h0FC, 9'h100, 9'h104, 9'h110};
            bit [8:0] rlist [6]  = '{9'h108, 9'h10C, 9'h110, 9'h114, 9'h0DC, 9'h0E8};
            @(posedge clk); #2;
            if ($urandom_range(0, 3) == 0)
                pins_in = {$urandom, $urandom};
            if ($urandom_range(0, 2) == 0) begin
                bus_wr    = 1'b1;
                bus_addr  = alist[$urandom_range(0, 11)];
                bus_wdata = (bus_addr == 9'h0DC) ? 32'($urandom_range(0, 4) != 0) : $urandom;
            end else begin
                bus_wr   = 1'b0;
                bus_addr = rlist[$urandom_range(0, 5)];
            end
        end
        @(posedge clk); #2;
        bus_wr = 1'b0;
        repeat (3) @(posedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule